// File: doc/BRIEF.md
# Two-Level Page Translation Walker

This block turns 32-bit linear addresses into physical addresses by walking a two-level translation structure kept in ordinary memory. The top ten address bits pick a word in a 4 KB directory. That word names a 4 KB table, and the next ten bits pick a word in it. The table word supplies the frame, and the low twelve bits pass through unchanged as the byte offset. Each lookup is a word read over a plain request/acknowledge memory port. After a successful lookup the block writes the used entries back with their accessed flag set, and with the modified flag set as well when the access is a store.

A requester offers one translation at a time with a valid/ready handshake, and gives the access type (load or store) and the privilege (supervisor or user). The block answers with a one-cycle response pulse. The pulse carries the physical address, or a fault flag and a 2-bit cause. Two configuration writes set the block up. The control word turns translation on with its bit 31. The base word gives the frame of the directory. When translation is off, the response echoes the linear address and no memory traffic happens.

Top module: `xlat_walker`

## Requirements
- R1: With translation off, an accepted request is answered on the cycle right after acceptance, with `rsp_phys` equal to `req_lin`, no fault, and no memory access.
- R2: A control write sets the enable from bit 31 of `cfg_wdata` and ignores all other bits. A base write keeps bits 31:12 as the directory frame and ignores bits 11:0. Both values are captured when a request is accepted.
- R3: The directory word is read at {frame, lin[31:22], 2'b00}. The table word is read at {directory word[31:12], lin[21:12], 2'b00}. A good result is {table word[31:12], lin[11:0]}.
- R4: `mem_req` stays high with a stable address, direction and data until `mem_ack`. Only one access is in flight at a time, and every address is word aligned.
- R5: A zero present flag (bit 0) ends the walk with cause 1. If the directory word is not present, the table word is never read.
- R6: A store faults with cause 2 when the writable flag (bit 1) is zero in the directory word, or zero in the table word.
- R7: A user access faults with cause 3 when the user flag (bit 2) is zero in either word. At a given level the privilege check comes before the store check, so a user store to a read-only supervisor page gives cause 3. Directory checks finish before the table word is read.
- R8: On success the accessed flag (bit 5) is written back into the directory word and the table word, and only into a word where it was still clear. A fault writes nothing.
- R9: A successful store also sets the modified flag (bit 6) in the table word. A load never sets it. A table word that already has every needed flag set is not rewritten.
- R10: When both words are written back, the directory write comes first. Every write-back finishes before the response pulse.
- R11: `req_ready` is high only while idle. `rsp_valid` lasts one cycle. `rsp_fault` is high exactly when `rsp_cause` is nonzero (0 none, 1 absent, 2 read-only, 3 privilege). A faulting response returns the linear address in `rsp_phys`.
- R12: A supervisor access ignores the user flags, and a load ignores the writable flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ctl_we | input | 1 | Write strobe for the control word |
| cfg_base_we | input | 1 | Write strobe for the directory base word |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle and able to accept |
| req_lin | input | 32 | Linear address to translate |
| req_write | input | 1 | 1 = store access, 0 = load |
| req_user | input | 1 | 1 = user privilege, 0 = supervisor |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_phys | output | 32 | Physical address (linear address on fault) |
| rsp_fault | output | 1 | Translation failed |
| rsp_cause | output | 2 | Fault cause: 1 absent, 2 read-only, 3 privilege |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Write-back data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access complete |

## Verification
The assertions watch the handshake shape on every cycle. Memory requests must hold steady until acknowledged and stay word aligned. Responses must be single pulses, with no memory request pending while they are out, and the fault flag must agree with the cause. Translation-off walks must stay off the memory port, and every write-back must carry the accessed flag. The bench scenarios alone can show the rest: the entry addresses that are computed, the order and priority of the permission checks, whether a write-back is skipped when flags are already set, and the exact bits left in memory. A memory model with variable latency sits behind those scenarios.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

   // Flag positions inside a directory or table word
   localparam int FLG_PRESENT = 0;
   localparam int FLG_WRITE   = 1;
   localparam int FLG_USER    = 2;
   localparam int FLG_ACC     = 5;
   localparam int FLG_DIRTY   = 6;

   typedef enum logic [1:0] {
      CAUSE_NONE   = 2'd0,
      CAUSE_ABSENT = 2'd1,
      CAUSE_RDONLY = 2'd2,
      CAUSE_PRIV   = 2'd3
   } cause_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DIR_RD,
      ST_TBL_RD,
      ST_DIR_WB,
      ST_TBL_WB,
      ST_RESP
   } walk_st_e;

endpackage

// File: rtl/xlat_cfg.sv
module xlat_cfg #(
   parameter int ADDR_W     = 32,
   parameter int PAGE_OFF_W = 12,
   parameter int CTL_EN_BIT = 31
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       ctl_we,
   input  logic                       base_we,
   input  logic [ADDR_W-1:0]          wdata,
   output logic                       paging_en,
   output logic [ADDR_W-PAGE_OFF_W-1:0] dir_frame
);

   localparam int FRAME_W = ADDR_W - PAGE_OFF_W;

   if (CTL_EN_BIT >= ADDR_W) begin : g_bad_en_bit
      $error("xlat_cfg: CTL_EN_BIT outside the data word");
   end

   logic               en_q;
   logic [FRAME_W-1:0] frame_q;
   logic               unused_cfg_bits;

   // Low base bits and the non-enable control bits are discarded
   assign unused_cfg_bits = ^wdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         frame_q <= '0;
      end else begin
         if (ctl_we)  en_q    <= wdata[CTL_EN_BIT];
         if (base_we) frame_q <= wdata[ADDR_W-1:PAGE_OFF_W];
      end
   end

   assign paging_en = en_q;
   assign dir_frame = frame_q;

endmodule

// File: rtl/xlat_perm_chk.sv
module xlat_perm_chk
   import xlat_pkg::*;
#(
   parameter bit PRIV_FIRST = 1'b1
) (
   input  logic   present,
   input  logic   writable,
   input  logic   user_ok,
   input  logic   acc_write,
   input  logic   acc_user,
   output cause_e cause
);

   logic priv_bad;
   logic wr_bad;

   assign priv_bad = acc_user && !user_ok;
   assign wr_bad   = acc_write && !writable;

   if (PRIV_FIRST) begin : g_priv_first
      always_comb begin
         if (!present)      cause = CAUSE_ABSENT;
         else if (priv_bad) cause = CAUSE_PRIV;
         else if (wr_bad)   cause = CAUSE_RDONLY;
         else               cause = CAUSE_NONE;
      end
   end else begin : g_write_first
      always_comb begin
         if (!present)      cause = CAUSE_ABSENT;
         else if (wr_bad)   cause = CAUSE_RDONLY;
         else if (priv_bad) cause = CAUSE_PRIV;
         else               cause = CAUSE_NONE;
      end
   end

endmodule

// File: rtl/xlat_walk_fsm.sv
module xlat_walk_fsm
   import xlat_pkg::*;
#(
   parameter int DIR_IDX_W   = 10,
   parameter int TBL_IDX_W   = 10,
   parameter int PAGE_OFF_W  = 12,
   parameter int ENTRY_BYTES = 4,
   parameter bit PRIV_FIRST  = 1'b1,
   parameter bit SKIP_SET_WB = 1'b1
) (
   input  logic                                    clk,
   input  logic                                    rst_n,
   input  logic                                    paging_en,
   input  logic [DIR_IDX_W+TBL_IDX_W-1:0]          dir_frame,
   input  logic                                    req_valid,
   output logic                                    req_ready,
   input  logic [DIR_IDX_W+TBL_IDX_W+PAGE_OFF_W-1:0] req_lin,
   input  logic                                    req_write,
   input  logic                                    req_user,
   output logic                                    rsp_valid,
   output logic [DIR_IDX_W+TBL_IDX_W+PAGE_OFF_W-1:0] rsp_phys,
   output cause_e                                  rsp_cause,
   output logic                                    mem_req,
   output logic                                    mem_we,
   output logic [DIR_IDX_W+TBL_IDX_W+PAGE_OFF_W-1:0] mem_addr,
   output logic [8*ENTRY_BYTES-1:0]                mem_wdata,
   input  logic [8*ENTRY_BYTES-1:0]                mem_rdata,
   input  logic                                    mem_ack,
   output logic                                    walk_paged
);

   localparam int ADDR_W   = DIR_IDX_W + TBL_IDX_W + PAGE_OFF_W;
   localparam int ENTRY_W  = 8 * ENTRY_BYTES;
   localparam int ENTRY_SH = $clog2(ENTRY_BYTES);
   localparam int FRAME_W  = ADDR_W - PAGE_OFF_W;
   localparam int DIR_LO   = TBL_IDX_W + PAGE_OFF_W;
   localparam logic [ENTRY_W-1:0] ACC_MASK   = ENTRY_W'(1) << FLG_ACC;
   localparam logic [ENTRY_W-1:0] DIRTY_MASK = ENTRY_W'(1) << FLG_DIRTY;

   if (ENTRY_W != ADDR_W) begin : g_bad_entry_w
      $error("xlat_walk_fsm: entry width must equal address width");
   end
   if (DIR_IDX_W + ENTRY_SH != PAGE_OFF_W) begin : g_bad_dir_size
      $error("xlat_walk_fsm: directory must fill exactly one page");
   end
   if (TBL_IDX_W + ENTRY_SH != PAGE_OFF_W) begin : g_bad_tbl_size
      $error("xlat_walk_fsm: table must fill exactly one page");
   end
   if (FLG_DIRTY >= PAGE_OFF_W) begin : g_bad_flags
      $error("xlat_walk_fsm: flag bits overlap the frame field");
   end

   walk_st_e            state_q;
   logic [ADDR_W-1:0]   lin_q;
   logic                wr_q;
   logic                usr_q;
   logic                en_q;
   logic [FRAME_W-1:0]  frame_q;
   logic [ENTRY_W-1:0]  pde_q;
   logic [ENTRY_W-1:0]  pte_q;
   logic                tbl_wb_q;
   logic [ADDR_W-1:0]   phys_q;
   cause_e              cause_q;

   logic [ADDR_W-1:0]   dir_addr;
   logic [ADDR_W-1:0]   tbl_addr;
   cause_e              dir_cause;
   cause_e              tbl_cause;
   logic                need_dir_wb;
   logic                need_tbl_wb;

   // Entry addresses: frame, index, zero byte lane
   assign dir_addr = {frame_q, lin_q[ADDR_W-1:DIR_LO], {ENTRY_SH{1'b0}}};
   assign tbl_addr = {pde_q[ADDR_W-1:PAGE_OFF_W], lin_q[DIR_LO-1:PAGE_OFF_W],
                      {ENTRY_SH{1'b0}}};

   // Directory-level check uses the word arriving on the bus
   xlat_perm_chk #(.PRIV_FIRST(PRIV_FIRST)) u_dir_chk (
      .present  (mem_rdata[FLG_PRESENT]),
      .writable (mem_rdata[FLG_WRITE]),
      .user_ok  (mem_rdata[FLG_USER]),
      .acc_write(wr_q),
      .acc_user (usr_q),
      .cause    (dir_cause)
   );

   // Table-level check combines both levels
   xlat_perm_chk #(.PRIV_FIRST(PRIV_FIRST)) u_tbl_chk (
      .present  (mem_rdata[FLG_PRESENT]),
      .writable (pde_q[FLG_WRITE] & mem_rdata[FLG_WRITE]),
      .user_ok  (pde_q[FLG_USER] & mem_rdata[FLG_USER]),
      .acc_write(wr_q),
      .acc_user (usr_q),
      .cause    (tbl_cause)
   );

   if (SKIP_SET_WB) begin : g_wb_when_clear
      assign need_dir_wb = !pde_q[FLG_ACC];
      assign need_tbl_wb = !mem_rdata[FLG_ACC] || (wr_q && !mem_rdata[FLG_DIRTY]);
   end else begin : g_wb_always
      assign need_dir_wb = 1'b1;
      assign need_tbl_wb = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         lin_q    <= '0;
         wr_q     <= 1'b0;
         usr_q    <= 1'b0;
         en_q     <= 1'b0;
         frame_q  <= '0;
         pde_q    <= '0;
         pte_q    <= '0;
         tbl_wb_q <= 1'b0;
         phys_q   <= '0;
         cause_q  <= CAUSE_NONE;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  lin_q   <= req_lin;
                  wr_q    <= req_write;
                  usr_q   <= req_user;
                  en_q    <= paging_en;
                  frame_q <= dir_frame;
                  phys_q  <= req_lin;
                  cause_q <= CAUSE_NONE;
                  state_q <= paging_en ? ST_DIR_RD : ST_RESP;
               end
            end
            ST_DIR_RD: begin
               if (mem_ack) begin
                  pde_q <= mem_rdata;
                  if (dir_cause != CAUSE_NONE) begin
                     cause_q <= dir_cause;
                     state_q <= ST_RESP;
                  end else begin
                     state_q <= ST_TBL_RD;
                  end
               end
            end
            ST_TBL_RD: begin
               if (mem_ack) begin
                  pte_q <= mem_rdata;
                  if (tbl_cause != CAUSE_NONE) begin
                     cause_q <= tbl_cause;
                     state_q <= ST_RESP;
                  end else begin
                     phys_q   <= {mem_rdata[ADDR_W-1:PAGE_OFF_W], lin_q[PAGE_OFF_W-1:0]};
                     tbl_wb_q <= need_tbl_wb;
                     if (need_dir_wb)      state_q <= ST_DIR_WB;
                     else if (need_tbl_wb) state_q <= ST_TBL_WB;
                     else                  state_q <= ST_RESP;
                  end
               end
            end
            ST_DIR_WB: begin
               if (mem_ack) state_q <= tbl_wb_q ? ST_TBL_WB : ST_RESP;
            end
            ST_TBL_WB: begin
               if (mem_ack) state_q <= ST_RESP;
            end
            ST_RESP: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_wdata = '0;
      case (state_q)
         ST_DIR_RD: begin
            mem_req  = 1'b1;
            mem_addr = dir_addr;
         end
         ST_TBL_RD: begin
            mem_req  = 1'b1;
            mem_addr = tbl_addr;
         end
         ST_DIR_WB: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = dir_addr;
            mem_wdata = pde_q | ACC_MASK;
         end
         ST_TBL_WB: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = tbl_addr;
            mem_wdata = pte_q | ACC_MASK | (wr_q ? DIRTY_MASK : '0);
         end
         default: ;
      endcase
   end

   assign req_ready  = (state_q == ST_IDLE);
   assign rsp_valid  = (state_q == ST_RESP);
   assign rsp_phys   = phys_q;
   assign rsp_cause  = cause_q;
   assign walk_paged = en_q;

endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
   import xlat_pkg::*;
#(
   parameter int DIR_IDX_W   = 10,
   parameter int TBL_IDX_W   = 10,
   parameter int PAGE_OFF_W  = 12,
   parameter int ENTRY_BYTES = 4,
   parameter int CTL_EN_BIT  = 31,
   parameter bit PRIV_FIRST  = 1'b1,
   parameter bit SKIP_SET_WB = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cfg_ctl_we,
   input  logic        cfg_base_we,
   input  logic [31:0] cfg_wdata,
   input  logic        req_valid,
   output logic        req_ready,
   input  logic [31:0] req_lin,
   input  logic        req_write,
   input  logic        req_user,
   output logic        rsp_valid,
   output logic [31:0] rsp_phys,
   output logic        rsp_fault,
   output logic [1:0]  rsp_cause,
   output logic        mem_req,
   output logic        mem_we,
   output logic [31:0] mem_addr,
   output logic [31:0] mem_wdata,
   input  logic [31:0] mem_rdata,
   input  logic        mem_ack
);

   localparam int ADDR_W  = DIR_IDX_W + TBL_IDX_W + PAGE_OFF_W;
   localparam int FRAME_W = ADDR_W - PAGE_OFF_W;

   if (ADDR_W != 32) begin : g_bad_addr_w
      $error("xlat_walker: index and offset widths must total 32");
   end
   if (ENTRY_BYTES != 4) begin : g_bad_entry
      $error("xlat_walker: entries must be 4 bytes for the 32-bit port");
   end

   logic               paging_en;
   logic [FRAME_W-1:0] dir_frame;
   cause_e             cause;
   logic               walk_paged;

   xlat_cfg #(
      .ADDR_W    (ADDR_W),
      .PAGE_OFF_W(PAGE_OFF_W),
      .CTL_EN_BIT(CTL_EN_BIT)
   ) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctl_we   (cfg_ctl_we),
      .base_we  (cfg_base_we),
      .wdata    (cfg_wdata),
      .paging_en(paging_en),
      .dir_frame(dir_frame)
   );

   xlat_walk_fsm #(
      .DIR_IDX_W  (DIR_IDX_W),
      .TBL_IDX_W  (TBL_IDX_W),
      .PAGE_OFF_W (PAGE_OFF_W),
      .ENTRY_BYTES(ENTRY_BYTES),
      .PRIV_FIRST (PRIV_FIRST),
      .SKIP_SET_WB(SKIP_SET_WB)
   ) u_walk (
      .clk       (clk),
      .rst_n     (rst_n),
      .paging_en (paging_en),
      .dir_frame (dir_frame),
      .req_valid (req_valid),
      .req_ready (req_ready),
      .req_lin   (req_lin),
      .req_write (req_write),
      .req_user  (req_user),
      .rsp_valid (rsp_valid),
      .rsp_phys  (rsp_phys),
      .rsp_cause (cause),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata),
      .mem_ack   (mem_ack),
      .walk_paged(walk_paged)
   );

   assign rsp_cause = cause;
   assign rsp_fault = (cause != CAUSE_NONE);

endmodule

// File: rtl/xlat_walker_chk.sv
module xlat_walker_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        req_ready,
   input logic        rsp_valid,
   input logic        rsp_fault,
   input logic [1:0]  rsp_cause,
   input logic        mem_req,
   input logic        mem_we,
   input logic [31:0] mem_addr,
   input logic [31:0] mem_wdata,
   input logic        mem_ack,
   input logic        walk_paged
);

   assert_cause_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_fault == (rsp_cause != 2'd0)));

   assert_rsp_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   assert_busy_on_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !req_ready);

   assert_ready_after_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> req_ready);

   assert_hold_until_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                 && $stable(mem_wdata)));

   assert_word_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[1:0] == 2'b00));

   assert_quiet_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !walk_paged |-> !mem_req);

   assert_wb_sets_acc_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> mem_wdata[5]);

   assert_mem_done_before_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !mem_req);

endmodule

bind xlat_walker xlat_walker_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .rsp_valid (rsp_valid),
   .rsp_fault (rsp_fault),
   .rsp_cause (rsp_cause),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .mem_ack   (mem_ack),
   .walk_paged(walk_paged)
);

// File: tb/xlat_walker_test.sv
module xlat_walker_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_ctl_we = 1'b0;
   logic        cfg_base_we = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_lin = '0;
   logic        req_write = 1'b0;
   logic        req_user = 1'b0;
   logic        rsp_valid;
   logic [31:0] rsp_phys;
   logic        rsp_fault;
   logic [1:0]  rsp_cause;
   logic        mem_req;
   logic        mem_we;
   logic [31:0] mem_addr;
   logic [31:0] mem_wdata;
   logic [31:0] mem_rdata = '0;
   logic        mem_ack = 1'b0;

   always #5 clk = ~clk;

   xlat_walker uut (
      .clk(clk), .rst_n(rst_n),
      .cfg_ctl_we(cfg_ctl_we), .cfg_base_we(cfg_base_we), .cfg_wdata(cfg_wdata),
      .req_valid(req_valid), .req_ready(req_ready), .req_lin(req_lin),
      .req_write(req_write), .req_user(req_user),
      .rsp_valid(rsp_valid), .rsp_phys(rsp_phys), .rsp_fault(rsp_fault),
      .rsp_cause(rsp_cause),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit summary_done = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // ---------------- memory model ----------------
   logic [31:0] mem_arr [logic [31:0]];
   int          lat = 0;
   int          wcnt = 0;
   int          n_rd = 0;
   int          n_wr = 0;
   logic [31:0] first_wa = '1;

   function automatic logic [31:0] rd(input logic [31:0] a);
      return mem_arr.exists(a) ? mem_arr[a] : 32'h0;
   endfunction

   always @(negedge clk) begin
      if (mem_ack) begin
         mem_ack = 1'b0;
      end else if (rst_n && mem_req) begin
         if (wcnt >= lat) begin
            wcnt = 0;
            mem_ack = 1'b1;
            if (mem_we) begin
               mem_arr[mem_addr] = mem_wdata;
               n_wr++;
               if (n_wr == 1) first_wa = mem_addr;
            end else begin
               mem_rdata = rd(mem_addr);
               n_rd++;
            end
         end else begin
            wcnt++;
         end
      end
   end

   // ---------------- scoreboard ----------------
   typedef struct {
      logic [31:0] phys;
      logic        fault;
      logic [1:0]  cause;
      bit          paged;
      int          nrd;
      int          nwr;
      logic [31:0] pa;
      logic [31:0] ta;
      logic [31:0] epde;
      logic [31:0] epte;
      string       tag;
   } exp_t;

   exp_t sb_q[$];
   int   done_cnt = 0;
   bit   tb_en = 1'b0;
   logic [31:0] tb_base = '0;

   // Expected result from the requirement rules
   function automatic exp_t model(input logic [31:0] lin, input bit wr, input bit usr,
                                  input string tag);
      exp_t e;
      logic [31:0] pde, pte;
      bit w, u;
      e.tag = tag; e.phys = lin; e.fault = 1'b0; e.cause = 2'd0;
      e.paged = tb_en; e.nrd = 0; e.nwr = 0;
      e.pa = '0; e.ta = '0; e.epde = '0; e.epte = '0;
      if (!tb_en) return e;
      e.pa = {tb_base[31:12], lin[31:22], 2'b00};
      pde = rd(e.pa); e.epde = pde; e.nrd = 1;
      if (!pde[0])             e.cause = 2'd1;
      else if (usr && !pde[2]) e.cause = 2'd3;
      else if (wr && !pde[1])  e.cause = 2'd2;
      if (e.cause != 0) begin e.fault = 1'b1; return e; end
      e.ta = {pde[31:12], lin[21:12], 2'b00};
      pte = rd(e.ta); e.epte = pte; e.nrd = 2;
      w = pde[1] & pte[1];
      u = pde[2] & pte[2];
      if (!pte[0])        e.cause = 2'd1;
      else if (usr && !u) e.cause = 2'd3;
      else if (wr && !w)  e.cause = 2'd2;
      if (e.cause != 0) begin e.fault = 1'b1; return e; end
      e.phys = {pte[31:12], lin[11:0]};
      e.epde = pde | 32'h20;
      e.epte = pte | 32'h20 | (wr ? 32'h40 : 32'h0);
      e.nwr  = int'(e.epde != pde) + int'(e.epte != pte);
      return e;
   endfunction

   exp_t got;
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (sb_q.size() == 0) begin
            chk(1'b0, "R11", "unexpected response", rsp_phys, 32'h0);
         end else begin
            got = sb_q.pop_front();
            chk(rsp_phys === got.phys, "R3", {got.tag, " phys"}, rsp_phys, got.phys);
            chk(rsp_fault === got.fault, "R11", {got.tag, " fault"},
                {31'h0, rsp_fault}, {31'h0, got.fault});
            chk(rsp_cause === got.cause, "R5", {got.tag, " cause"},
                {30'h0, rsp_cause}, {30'h0, got.cause});
            chk(n_rd == got.nrd, "R5", {got.tag, " reads"}, n_rd, got.nrd);
            chk(n_wr == got.nwr, "R8", {got.tag, " writes"}, n_wr, got.nwr);
            if (got.nrd >= 1)
               chk(rd(got.pa) === got.epde, "R8", {got.tag, " dir word"},
                   rd(got.pa), got.epde);
            if (got.nrd == 2)
               chk(rd(got.ta) === got.epte, "R9", {got.tag, " table word"},
                   rd(got.ta), got.epte);
            if (got.nwr == 2)
               chk(first_wa === got.pa, "R10", {got.tag, " write order"},
                   first_wa, got.pa);
         end
         done_cnt++;
      end
   end

   // ---------------- driver ----------------
   task automatic cfg_write(input bit is_base, input logic [31:0] d);
      @(negedge clk);
      cfg_wdata = d;
      if (is_base) begin cfg_base_we = 1'b1; tb_base = {d[31:12], 12'h0}; end
      else begin cfg_ctl_we = 1'b1; tb_en = d[31]; end
      @(negedge clk);
      cfg_base_we = 1'b0;
      cfg_ctl_we  = 1'b0;
   endtask

   task automatic issue(input logic [31:0] lin, input bit wr, input bit usr,
                        input string tag);
      exp_t e;
      int tgt;
      e = model(lin, wr, usr, tag);
      sb_q.push_back(e);
      tgt = done_cnt + 1;
      @(negedge clk);
      n_rd = 0; n_wr = 0; first_wa = '1;
      req_lin = lin; req_write = wr; req_user = usr; req_valid = 1'b1;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      if (!e.paged)
         chk(rsp_valid === 1'b1, "R1", {tag, " one-cycle passthrough"},
             {31'h0, rsp_valid}, 32'h1);
      while (done_cnt < tgt) @(negedge clk);
   endtask

   initial begin
      // Directory at 0x00100000
      mem_arr[32'h0010_0000] = 32'h0010_1007;           // idx 0
      mem_arr[32'h0010_0004] = 32'h0000_0000;           // idx 1 absent
      mem_arr[32'h0010_0008] = 32'h0010_2005;           // idx 2 read-only
      mem_arr[32'h0010_000C] = 32'h0010_3003;           // idx 3 supervisor
      mem_arr[32'h0010_0010] = 32'h0010_4067;           // idx 4 flagged
      mem_arr[32'h0010_0C00] = 32'h0010_1007;           // idx 768
      // Table at 0x00101000
      mem_arr[32'h0010_1014] = 32'h00AB_C007;           // 5
      mem_arr[32'h0010_1018] = 32'h0000_0000;           // 6 absent
      mem_arr[32'h0010_101C] = 32'h00DE_F005;           // 7 read-only
      mem_arr[32'h0010_1020] = 32'h00FE_D003;           // 8 supervisor
      mem_arr[32'h0010_1024] = 32'h0044_4001;           // 9 present only
      mem_arr[32'h0010_2004] = 32'h0011_1007;
      mem_arr[32'h0010_3004] = 32'h0022_2007;
      mem_arr[32'h0010_4008] = 32'h0033_3067;

      repeat (4) @(negedge clk);
      chk(req_ready === 1'b1, "R11", "reset ready", {31'h0, req_ready}, 32'h1);
      chk(rsp_valid === 1'b0, "R11", "reset rsp", {31'h0, rsp_valid}, 32'h0);
      chk(mem_req === 1'b0, "R4", "reset mem_req", {31'h0, mem_req}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready === 1'b1, "R11", "idle ready", {31'h0, req_ready}, 32'h1);

      // R1/R2: control word without bit 31 leaves translation off
      cfg_write(1'b0, 32'h7FFF_FFFF);
      issue(32'hC012_3ABC, 1'b1, 1'b1, "R1 off passthrough");

      // R2: base low bits ignored, enable from bit 31 only
      cfg_write(1'b1, 32'h0010_0ABC);
      cfg_write(1'b0, 32'h8000_0000);

      lat = 1;
      issue(32'h0000_5123, 1'b0, 1'b1, "R3 user load");
      issue(32'h0000_5456, 1'b1, 1'b1, "R9 store sets dirty");
      issue(32'h0000_5789, 1'b1, 1'b1, "R9 flags already set");
      lat = 0;
      issue(32'hC000_5FFF, 1'b0, 1'b0, "R8 upper mapping");
      issue(32'h0040_0000, 1'b0, 1'b0, "R5 dir absent");
      issue(32'h0000_6000, 1'b0, 1'b0, "R5 table absent");
      lat = 2;
      issue(32'h0000_7010, 1'b1, 1'b1, "R6 table read-only store");
      issue(32'h0000_7020, 1'b0, 1'b1, "R12 read-only load");
      issue(32'h0000_8030, 1'b0, 1'b1, "R7 table supervisor page");
      issue(32'h0000_8040, 1'b1, 1'b0, "R12 supervisor store");
      lat = 0;
      issue(32'h0080_1050, 1'b1, 1'b0, "R6 dir read-only store");
      issue(32'h0080_1060, 1'b0, 1'b1, "R12 dir read-only load");
      issue(32'h00C0_1070, 1'b0, 1'b1, "R7 dir supervisor");
      issue(32'h0000_9080, 1'b1, 1'b1, "R7 priv before write");
      issue(32'h0100_2090, 1'b1, 1'b0, "R9 preflagged store");

      cfg_write(1'b0, 32'h0000_0000);
      issue(32'h0000_5123, 1'b0, 1'b1, "R1 off again");

      repeat (3) @(negedge clk);
      if (!summary_done) begin
         summary_done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      end
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!summary_done) begin
         summary_done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      end
      $finish;
   end

endmodule